// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the byte a NOR-style flash returns when it is read while an internal program or erase algorithm runs. A controller supplies the current operation state, the read strobe, the sector of the read address, the set of sectors selected for erase (or suspended), a flag that marks the read as hitting the location being programmed, bit 7 of the target data, and the array data word. On each read strobe the block registers either a status byte or the array data on its output.

The status byte carries a data-polling bit, a primary toggle bit that flips on status reads during active algorithms, a secondary toggle bit that flips only on reads of sectors under erase, an erase-timer bit that separates the sector-erase acceptance window from the real erase, and an exceeded-time bit. The exceeded-time bit comes from an internal pulse counter. Once the count passes a parameter limit, the failure latches. The device then answers every read with status until a reset command clears it.

Top module: `flash_status_gen`

## Requirements
- R1: After rst_ni is released, rdata_o is 0x00 and rdata_valid_o is 0.
- R2: A read strobe sampled at a rising edge sets rdata_valid_o high for the next cycle. With op_i idle (3'd0, or the unused codes 3'd6 and 3'd7) and no latched failure, rdata_o then equals array_i.
- R3: Status byte bit 7 (polling) is the complement of tgt_d7_i in program (3'd1) and suspend-program (3'd5). It is 0 in erase window (3'd2) and erasing (3'd3). It is 1 in suspend-read (3'd4).
- R4: Status byte bit 6 (primary toggle) inverts on each status read in program, erase window, erasing and suspend-program. It holds its value in suspend-read.
- R5: Status byte bit 2 (secondary toggle) inverts on each read of a sector whose erase_mask_i bit is set, in erase window, erasing and suspend-read. It holds on other reads. A suspend-program read with prog_addr_i high returns 1 in bit 2.
- R6: Status byte bit 3 (erase timer) is 0 in program and erase window. It is 1 in erasing, suspend-read and suspend-program.
- R7: pulse_i ticks are counted while op_i is program, erasing or suspend-program. A tick that arrives with PULSE_LIMIT ticks already counted latches the failure. Every later status read returns 1 in bit 5. The count clears while op_i is idle.
- R8: The failure stays latched when op_i returns to idle. Reads then return the program-form status byte, and bit 6 keeps inverting.
- R9: reset_cmd_i clears the failure and the pulse count. The next idle read returns array_i.
- R10: In suspend-read, a read of a sector whose erase_mask_i bit is clear returns array_i. In suspend-program, a read with prog_addr_i low returns array_i. Neither read changes either toggle bit.
- R11: Without a read strobe, rdata_o holds its value and rdata_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation state: 0 idle, 1 program, 2 erase window, 3 erasing, 4 suspend-read, 5 suspend-program |
| rd_i | input | 1 | Read strobe |
| rd_sector_i | input | SECT_W | Sector of the read address |
| erase_mask_i | input | NUM_SECT | Sectors under erase or suspended |
| prog_addr_i | input | 1 | Read address equals the programming target |
| tgt_d7_i | input | 1 | Bit 7 of the data being programmed |
| array_i | input | 8 | Array data for the read address |
| pulse_i | input | 1 | Internal algorithm pulse tick |
| reset_cmd_i | input | 1 | Reset command, clears the failure |
| rdata_o | output | 8 | Read data or status byte |
| rdata_valid_o | output | 1 | rdata_o was updated by a read at the last edge |

## Verification
Every read result appears on rdata_o exactly one clock after the edge that samples rd_i. The toggle bits inside that result already carry the flip caused by that same read. A pulse tick latches the failure at its own edge, so bit 5 shows on a read sampled one edge later. The bench drives inputs and samples outputs on the falling edge, advances its reference model on each rising edge, and compares both outputs every cycle against the model's value for the edge just passed.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE_WIN = 3'd2,
    OP_ERASING   = 3'd3,
    OP_SUSP_READ = 3'd4,
    OP_SUSP_PROG = 3'd5
  } op_e;

  localparam int BIT_POLL  = 7;
  localparam int BIT_TOG1  = 6;
  localparam int BIT_FAIL  = 5;
  localparam int BIT_TIMER = 3;
  localparam int BIT_TOG2  = 2;
endpackage

// File: rtl/fsg_pulse_timer.sv
module fsg_pulse_timer
  import flash_status_pkg::*;
#(
  parameter int PULSE_LIMIT = 1000,
  localparam int CNT_W = $clog2(PULSE_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  op_e  op_i,
  input  logic pulse_i,
  input  logic reset_cmd_i,
  output logic fail_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fail_q;
  logic             counting;

  assign counting = (op_i == OP_PROG) || (op_i == OP_ERASING) || (op_i == OP_SUSP_PROG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (reset_cmd_i) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (op_i == OP_IDLE) begin
      cnt_q  <= '0;
    end else if (pulse_i && counting && !fail_q) begin
      if (cnt_q == CNT_W'(PULSE_LIMIT)) fail_q <= 1'b1;
      else                              cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/fsg_toggle_unit.sv
module fsg_toggle_unit
  import flash_status_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  op_e  eff_op_i,
  input  logic sect_hit_i,
  input  logic prog_addr_i,
  output logic tog1_o,   // value including this read's flip
  output logic tog2_o
);
  logic tog1_q, tog2_q, flip1, flip2;

  always_comb begin
    flip1 = 1'b0;
    flip2 = 1'b0;
    if (rd_i) begin
      case (eff_op_i)
        OP_PROG, OP_ERASE_WIN: flip1 = 1'b1;
        OP_ERASING:            flip1 = 1'b1;
        OP_SUSP_PROG:          flip1 = prog_addr_i;
        default:               flip1 = 1'b0;
      endcase
      flip2 = sect_hit_i && ((eff_op_i == OP_ERASE_WIN) || (eff_op_i == OP_ERASING) ||
                             (eff_op_i == OP_SUSP_READ));
    end
  end

  assign tog1_o = tog1_q ^ flip1;
  assign tog2_o = tog2_q ^ flip2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog1_q <= 1'b0;
      tog2_q <= 1'b0;
    end else begin
      tog1_q <= tog1_o;
      tog2_q <= tog2_o;
    end
  end
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
  import flash_status_pkg::*;
(
  input  op_e        eff_op_i,
  input  logic       fail_i,
  input  logic       sect_hit_i,
  input  logic       prog_addr_i,
  input  logic       tgt_d7_i,
  input  logic       tog1_i,
  input  logic       tog2_i,
  input  logic [7:0] array_i,
  output logic [7:0] data_o
);
  logic [7:0] st;
  logic       is_stat;

  always_comb begin
    st            = '0;
    st[BIT_TOG1]  = tog1_i;
    st[BIT_FAIL]  = fail_i;
    st[BIT_TOG2]  = tog2_i;
    is_stat       = 1'b1;
    case (eff_op_i)
      OP_PROG:      st[BIT_POLL] = ~tgt_d7_i;
      OP_ERASE_WIN: st[BIT_TIMER] = 1'b0;
      OP_ERASING:   st[BIT_TIMER] = 1'b1;
      OP_SUSP_READ: begin
        is_stat       = sect_hit_i;
        st[BIT_POLL]  = 1'b1;
        st[BIT_TIMER] = 1'b1;
      end
      OP_SUSP_PROG: begin
        is_stat       = prog_addr_i;
        st[BIT_POLL]  = ~tgt_d7_i;
        st[BIT_TIMER] = 1'b1;
        st[BIT_TOG2]  = 1'b1;
      end
      default:      is_stat = 1'b0;
    endcase
    data_o = is_stat ? st : array_i;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int NUM_SECT    = 8,
  parameter int PULSE_LIMIT = 1000,
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          op_i,
  input  logic                rd_i,
  input  logic [SECT_W-1:0]   rd_sector_i,
  input  logic [NUM_SECT-1:0] erase_mask_i,
  input  logic                prog_addr_i,
  input  logic                tgt_d7_i,
  input  logic [7:0]          array_i,
  input  logic                pulse_i,
  input  logic                reset_cmd_i,
  output logic [7:0]          rdata_o,
  output logic                rdata_valid_o
);
  op_e        op_raw, eff_op;
  logic       fail_q, sect_hit, tog1, tog2;
  logic [7:0] mux_data, rdata_q;
  logic       valid_q;

  assign op_raw   = (op_i <= 3'd5) ? op_e'(op_i) : OP_IDLE;
  // a latched failure keeps the part answering with program status
  assign eff_op   = (fail_q && op_raw == OP_IDLE) ? OP_PROG : op_raw;
  assign sect_hit = (32'(rd_sector_i) < NUM_SECT) ? erase_mask_i[rd_sector_i] : 1'b0;

  fsg_pulse_timer #(.PULSE_LIMIT(PULSE_LIMIT)) u_timer (
    .clk_i, .rst_ni, .op_i(op_raw), .pulse_i, .reset_cmd_i, .fail_o(fail_q)
  );

  fsg_toggle_unit u_tog (
    .clk_i, .rst_ni, .rd_i, .eff_op_i(eff_op), .sect_hit_i(sect_hit),
    .prog_addr_i, .tog1_o(tog1), .tog2_o(tog2)
  );

  fsg_status_mux u_mux (
    .eff_op_i(eff_op), .fail_i(fail_q), .sect_hit_i(sect_hit), .prog_addr_i,
    .tgt_d7_i, .tog1_i(tog1), .tog2_i(tog2), .array_i, .data_o(mux_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_i;
      if (rd_i) rdata_q <= mux_data;
    end
  end

  assign rdata_o       = rdata_q;
  assign rdata_valid_o = valid_q;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] op_i,
  input logic       rd_i,
  input logic       reset_cmd_i,
  input logic       fail_i,
  input logic [7:0] rdata_o,
  input logic       rdata_valid_o
);
  a_r2_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rdata_valid_o);

  a_r11_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (!rdata_valid_o && $stable(rdata_o)));

  a_r3_erase_poll_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (op_i == 3'd2 || op_i == 3'd3)) |=> !rdata_o[7]);

  a_r6_window_timer_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && op_i == 3'd2) |=> !rdata_o[3]);

  a_r7_fail_bit_shown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && fail_i && op_i != 3'd4 && op_i != 3'd5) |=> rdata_o[5]);

  a_r8_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !reset_cmd_i) |=> fail_i);

  a_r9_cmd_clears_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_cmd_i |=> !fail_i);
endmodule

bind flash_status_gen fsg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .rd_i(rd_i),
  .reset_cmd_i(reset_cmd_i), .fail_i(fail_q), .rdata_o(rdata_o),
  .rdata_valid_o(rdata_valid_o)
);

// File: tb/tb_flash_status_gen.sv
`timescale 1ns/1ps
module tb_flash_status_gen;
  localparam int NS = 4;
  localparam int LIM = 6;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic rd = 0, paddr = 0, d7 = 0, pulse = 0, rcmd = 0;
  logic [SW-1:0] sect = '0;
  logic [NS-1:0] mask = '0;
  logic [7:0] arr = 8'h00;
  logic [7:0] rdata;
  logic valid;

  int n_run = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  int m_t1 = 0, m_t2 = 0, m_cnt = 0, m_fail = 0;
  logic [7:0] e_data = 8'h00;
  logic e_valid = 1'b0;

  always #4 clk = ~clk;

  flash_status_gen #(.NUM_SECT(NS), .PULSE_LIMIT(LIM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .rd_i(rd), .rd_sector_i(sect),
    .erase_mask_i(mask), .prog_addr_i(paddr), .tgt_d7_i(d7), .array_i(arr),
    .pulse_i(pulse), .reset_cmd_i(rcmd), .rdata_o(rdata), .rdata_valid_o(valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t1 = 0; m_t2 = 0; m_cnt = 0; m_fail = 0; e_data = 8'h00; e_valid = 1'b0;
    end else begin
      int o, e;
      bit hit, stat;
      logic [7:0] s;
      o = (op > 3'd5) ? 0 : int'(op);
      e = (m_fail != 0 && o == 0) ? 1 : o;
      hit = mask[sect];
      e_valid = rd;
      if (rd) begin
        stat = 1; s = 8'h00;
        case (e)
          1: begin m_t1 ^= 1; s[7] = ~d7; end
          2: begin m_t1 ^= 1; if (hit) m_t2 ^= 1; end
          3: begin m_t1 ^= 1; if (hit) m_t2 ^= 1; s[3] = 1; end
          4: begin stat = hit; if (hit) m_t2 ^= 1; s[7] = 1; s[3] = 1; end
          5: begin stat = paddr; if (paddr) m_t1 ^= 1; s[7] = ~d7; s[3] = 1; end
          default: stat = 0;
        endcase
        s[6] = m_t1[0]; s[5] = (m_fail != 0); s[2] = m_t2[0];
        if (e == 5) s[2] = 1'b1;
        e_data = stat ? s : arr;
      end
      if (rcmd) begin m_cnt = 0; m_fail = 0; end
      else if (o == 0) m_cnt = 0;
      else if (pulse && (o == 1 || o == 3 || o == 5) && m_fail == 0) begin
        if (m_cnt == LIM) m_fail = 1; else m_cnt++;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk({cur_req, " data"}, int'(rdata), int'(e_data));
    chk({cur_req, " valid"}, int'(valid), int'(e_valid));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    rd = 0; pulse = 0; rcmd = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rdo(input logic [SW-1:0] s, input logic [7:0] a);
    rd = 1; sect = s; arr = a; @(negedge clk); rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 reset data", int'(rdata), 0);
    chk("R1 reset valid", int'(valid), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release", int'(rdata), 0);

    cur_req = "R2";
    rdo(0, 8'h5A); rdo(3, 8'hC3);
    op = 3'd7; rdo(1, 8'h81); op = 3'd0;
    @(negedge clk);
    chk("R2 idle array data", int'(rdata), 8'h81);
    cur_req = "R11"; arr = 8'hFF; idle(3);
    chk("R11 held", int'(rdata), 8'h81);

    cur_req = "R3"; op = 3'd1; d7 = 1; rdo(0, 8'h11);
    chk("R3 poll complement", int'(rdata[7]), 0);
    cur_req = "R4"; d7 = 0; rdo(0, 8'h11); rdo(0, 8'h11); rdo(2, 8'h11);
    cur_req = "R6"; rdo(0, 8'h00);
    chk("R6 timer low in program", int'(rdata[3]), 0);

    cur_req = "R5"; op = 3'd0; idle(1); op = 3'd2; mask = 4'b0010;
    rdo(1, 8'h00); rdo(2, 8'h00); rdo(1, 8'h00); rdo(3, 8'h00);
    cur_req = "R6"; op = 3'd3; rdo(1, 8'h00);
    chk("R6 timer high erasing", int'(rdata[3]), 1);
    cur_req = "R3"; rdo(0, 8'h00); rdo(1, 8'h00);
    chk("R3 poll zero erasing", int'(rdata[7]), 0);

    cur_req = "R4"; op = 3'd4; rdo(1, 8'h00); rdo(1, 8'h00); rdo(1, 8'h00);
    cur_req = "R10"; rdo(0, 8'hA7);
    chk("R10 suspend-read other sector", int'(rdata), 8'hA7);
    rdo(2, 8'h3C);

    cur_req = "R5"; op = 3'd5; paddr = 1; d7 = 1; rdo(0, 8'h00);
    chk("R5 tog2 one at prog addr", int'(rdata[2]), 1);
    rdo(0, 8'h00);
    cur_req = "R10"; paddr = 0; rdo(1, 8'h96);
    chk("R10 suspend-prog other addr", int'(rdata), 8'h96);

    cur_req = "R7"; op = 3'd0; idle(1); op = 3'd1;
    for (int i = 0; i < LIM; i++) begin pulse = 1; @(negedge clk); end
    pulse = 0; op = 3'd4; pulse = 1; @(negedge clk); pulse = 0;  // not counted
    op = 3'd1; rdo(0, 8'h00);
    chk("R7 no fail at limit", int'(rdata[5]), 0);
    pulse = 1; @(negedge clk); pulse = 0;
    rdo(0, 8'h00);
    chk("R7 fail bit set", int'(rdata[5]), 1);

    cur_req = "R8"; op = 3'd0; idle(2); rdo(0, 8'h42); rdo(1, 8'h42); rdo(3, 8'h42);
    chk("R8 status while failed", int'(rdata[5]), 1);

    cur_req = "R9"; rcmd = 1; @(negedge clk); rcmd = 0;
    rdo(0, 8'h24);
    chk("R9 array after reset cmd", int'(rdata), 8'h24);

    cur_req = "R7"; op = 3'd3;
    for (int i = 0; i < LIM - 2; i++) begin pulse = 1; @(negedge clk); end
    pulse = 0; op = 3'd0; idle(1); op = 3'd3;
    for (int i = 0; i < LIM - 2; i++) begin pulse = 1; @(negedge clk); end
    pulse = 0; rdo(1, 8'h00);
    chk("R7 count cleared at idle", int'(rdata[5]), 0);
    op = 3'd0; idle(3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule